// File: doc/BRIEF.md
# Baseband Serial Receive Port Controller

This block sits on the MAC side of a serial receive link from a baseband modem. It arms the modem by raising an enable line, waits for the modem's ready indication, then samples the modem's serial data on rising edges of the modem-driven receive clock. Bits are packed into bytes, least significant bit first, and each byte leaves on a valid/data/last stream. The receive clock is asynchronous to the system clock. It is brought through a synchroniser and edge-detected, and all timing windows are counted in system clock cycles.

Reception ends in one of three ways. The programmed byte count can be reached, in which case the final byte carries the last flag. An abort request can arrive, in which case the enable is dropped just after the next receive clock edge. Or the modem can withdraw its ready indication early, in which case a truncation beat with an error flag is emitted. In every case the enable is dropped in the safe window after a clock edge, so the modem stops sending clocks. The controller then waits for the ready line to fall and keeps the enable low for a minimum gap before it accepts a new start. Each activation restarts the modem's channel and signal-strength measurement. A one-cycle strobe marks the point, a fixed number of cycles later, at which those readings are valid.

Top module: `rxSerialPort`

## Requirements
- R1: After reset, rxEnOut, outValid, outLast, outErr and measValid are all low.
- R2: A one-cycle startReq while idle with a nonzero byteCount raises rxEnOut at the next clock edge. A startReq with byteCount equal to 0 is ignored, and rxEnOut stays low.
- R3: While modemRdyIn is high and a packet is being received, rxDataIn is sampled on each rising edge of rxClkIn. Every eight samples form one byte with the first sample in bit 0, and the byte is presented as a one-cycle outValid beat with outErr low. Receive clock edges seen while modemRdyIn is low produce no output.
- R4: The byte that brings the received count to byteCount carries outLast high, and earlier bytes carry outLast low. rxEnOut falls within 12 system cycles of the rising receive clock edge that completed that byte.
- R5: After rxEnOut falls, the controller waits for modemRdyIn to go low. It then holds rxEnOut low for at least GAP_CYC cycles. A startReq arriving before that gap ends is ignored.
- R6: An abortReq before modemRdyIn has been seen drops rxEnOut at the next clock edge. An abortReq during reception holds rxEnOut high until the next rising receive clock edge and drops it right after. The bit at that edge and any partial byte are discarded.
- R7: If modemRdyIn falls before byteCount bytes have arrived, one beat is emitted with outValid, outLast and outErr high and outData equal to 0x00, and rxEnOut falls.
- R8: measValid pulses high for exactly one cycle, MEAS_CYC cycles after rxEnOut rises. There is one pulse per activation, and none if rxEnOut falls before that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle request to arm the receiver |
| abortReq | input | 1 | One-cycle request to end reception early |
| byteCount | input | LEN_W | Expected packet length in bytes, held stable during a packet |
| rxEnOut | output | 1 | Receive enable to the modem |
| modemRdyIn | input | 1 | Modem indication that payload bits are being delivered |
| rxDataIn | input | 1 | Serial receive data from the modem |
| rxClkIn | input | 1 | Receive bit clock driven by the modem |
| outValid | output | 1 | Output byte strobe |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Marks the final beat of a packet |
| outErr | output | 1 | Marks a truncated packet |
| measValid | output | 1 | Strobe: channel and signal-strength readings are now valid |

## Verification
The bench targets the points where reception has to stop at a clock-edge boundary. After the last counted byte, a controller that drops the enable late would let the modem clock out an extra bit. One that drops it early would lose part of the final byte. An abort during reception must wait for an edge and then discard the partial byte. A design that drops the enable at once, or that flushes the partial byte, would show up as a missing or extra beat. The bench also starts a packet during the re-arm gap and times the wait until the enable can rise again. It checks that the measurement strobe appears exactly MEAS_CYC cycles after each activation and never after an early abort, and that a zero length and edges seen before the ready indication have no effect.

// File: rtl/rxPortPkg.sv
`timescale 1ns/1ps
package rxPortPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_RECV,
    ST_STOP,
    ST_GAP
  } rxState_t;

  // Strobes from control to the datapath
  typedef struct packed {
    logic clear;   // reset bit and byte counters for a new packet
    logic accept;  // sample bits on receive clock edges
    logic trunc;   // emit a truncation error beat
  } dpCtl_t;
endpackage

// File: rtl/rxPortDp.sv
`timescale 1ns/1ps
module rxPortDp
  import rxPortPkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [LEN_W-1:0]  byteCount,
  input  logic              modemRdyIn,
  input  logic              rxDataIn,
  input  logic              rxClkIn,
  output logic              rdySync,
  output logic              clkEdge,
  output logic              lastByte,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outLast,
  output logic              outErr
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int TOP   = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkSh, datSh, rdySh;
  logic                   clkPrev;
  logic                   datSync;
  logic [BYTE_W-1:0]      shReg, shNext;
  logic [BIT_W-1:0]       bitCnt;
  logic [LEN_W-1:0]       byteCnt, cntNext;
  logic                   take, byteDone;

  // Synchronisers for the three modem-driven lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSh   <= '0;
      datSh   <= '0;
      rdySh   <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkSh   <= {clkSh[TOP-1:0], rxClkIn};
      datSh   <= {datSh[TOP-1:0], rxDataIn};
      rdySh   <= {rdySh[TOP-1:0], modemRdyIn};
      clkPrev <= clkSh[TOP];
    end
  end

  assign rdySync  = rdySh[TOP];
  assign datSync  = datSh[TOP];
  assign clkEdge  = clkSh[TOP] & ~clkPrev;

  assign take     = ctl.accept & clkEdge & rdySync;
  assign shNext   = {datSync, shReg[BYTE_W-1:1]};
  assign byteDone = take && (bitCnt == BIT_W'(BYTE_W - 1));
  assign cntNext  = byteCnt + 1'b1;
  assign lastByte = byteDone && (cntNext == byteCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitCnt   <= '0;
      byteCnt  <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
      outErr   <= 1'b0;
    end else begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outErr   <= 1'b0;
      if (ctl.clear) begin
        shReg   <= '0;
        bitCnt  <= '0;
        byteCnt <= '0;
      end else if (ctl.trunc) begin
        outValid <= 1'b1;
        outLast  <= 1'b1;
        outErr   <= 1'b1;
        outData  <= '0;
      end else if (take) begin
        shReg  <= shNext;
        bitCnt <= bitCnt + 1'b1;
        if (byteDone) begin
          outValid <= 1'b1;
          outData  <= shNext;
          outLast  <= lastByte;
          byteCnt  <= cntNext;
        end
      end
    end
  end

  // R4: a clean last beat coincides with the programmed count
  a_r4_last_count: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast && !outErr) |-> (byteCnt == byteCount));

  // R3: a data beat needs the ready line high on the sampling cycle
  a_r3_beat_needs_rdy: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outErr) |-> $past(rdySync));
endmodule

// File: rtl/rxPortCtl.sv
`timescale 1ns/1ps
module rxPortCtl
  import rxPortPkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int MEAS_CYC = 2000,
  parameter int GAP_CYC  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic [LEN_W-1:0] byteCount,
  input  logic             rdySync,
  input  logic             clkEdge,
  input  logic             lastByte,
  output dpCtl_t           ctl,
  output logic             rxEnOut,
  output logic             measValid
);
  localparam int MEAS_W = $clog2(MEAS_CYC + 1);
  localparam int GAP_W  = $clog2(GAP_CYC + 1);

  rxState_t    state, nextState;
  logic        abortPend;
  logic [GAP_W-1:0]  gapCnt;
  logic [MEAS_W-1:0] measCnt;
  logic        measArmed;
  logic        goArm, enabled;

  assign enabled = (state == ST_ARM) || (state == ST_RECV);
  assign rxEnOut = enabled;
  assign goArm   = (state == ST_IDLE) && startReq && (byteCount != '0);

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (goArm) begin
        nextState = ST_ARM;
        ctl.clear = 1'b1;
      end
      ST_ARM: begin
        if (abortReq)     nextState = ST_STOP;
        else if (rdySync) nextState = ST_RECV;
      end
      ST_RECV: begin
        ctl.accept = !(abortPend || abortReq);
        if (lastByte) nextState = ST_STOP;
        else if (!rdySync) begin
          ctl.trunc = 1'b1;
          nextState = ST_STOP;
        end else if ((abortPend || abortReq) && clkEdge) nextState = ST_STOP;
      end
      ST_STOP: if (!rdySync) nextState = ST_GAP;
      ST_GAP:  if (gapCnt == GAP_W'(GAP_CYC - 1)) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      abortPend <= 1'b0;
      gapCnt    <= '0;
    end else begin
      state     <= nextState;
      abortPend <= (state == ST_RECV) && nextState == ST_RECV && (abortPend || abortReq);
      if (state == ST_GAP) gapCnt <= gapCnt + 1'b1;
      else                 gapCnt <= '0;
    end
  end

  // Measurement-valid timer, restarted by every activation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measCnt   <= '0;
      measArmed <= 1'b0;
      measValid <= 1'b0;
    end else begin
      measValid <= 1'b0;
      if (goArm) begin
        measCnt   <= '0;
        measArmed <= 1'b1;
      end else if (measArmed) begin
        if (!enabled) measArmed <= 1'b0;
        else if (measCnt == MEAS_W'(MEAS_CYC - 1)) begin
          measValid <= 1'b1;
          measArmed <= 1'b0;
        end else measCnt <= measCnt + 1'b1;
      end
    end
  end

  // Checker-only counter of enable-low cycles, saturating at the gap
  logic [GAP_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             lowCnt <= GAP_W'(GAP_CYC);
    else if (rxEnOut)                      lowCnt <= '0;
    else if (lowCnt != GAP_W'(GAP_CYC))    lowCnt <= lowCnt + 1'b1;
  end

  // R5: enable never rises before the gap has elapsed
  a_r5_gap_respected: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnOut) |-> (lowCnt == GAP_W'(GAP_CYC)));

  // R4: completing the final byte drops the enable on the next edge
  a_r4_drop_after_last: assert property (@(posedge clk) disable iff (!rstN)
    lastByte |=> !rxEnOut);

  // R6: abort before data drops the enable at once
  a_r6_abort_arm: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARM && abortReq) |=> !rxEnOut);

  // R8: measurement strobe is a single-cycle pulse
  a_r8_meas_pulse: assert property (@(posedge clk) disable iff (!rstN)
    measValid |=> !measValid);
endmodule

// File: rtl/rxSerialPort.sv
`timescale 1ns/1ps
module rxSerialPort
  import rxPortPkg::*;
#(
  parameter int LEN_W       = 12,
  parameter int MEAS_CYC    = 2000,
  parameter int GAP_CYC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic [LEN_W-1:0] byteCount,
  output logic             rxEnOut,
  input  logic             modemRdyIn,
  input  logic             rxDataIn,
  input  logic             rxClkIn,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             outLast,
  output logic             outErr,
  output logic             measValid
);
  dpCtl_t ctl;
  logic   rdySync, clkEdge, lastByte;

  rxPortCtl #(.LEN_W(LEN_W), .MEAS_CYC(MEAS_CYC), .GAP_CYC(GAP_CYC)) uCtl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .byteCount(byteCount), .rdySync(rdySync), .clkEdge(clkEdge),
    .lastByte(lastByte), .ctl(ctl), .rxEnOut(rxEnOut), .measValid(measValid)
  );

  rxPortDp #(.LEN_W(LEN_W), .BYTE_W(8), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteCount(byteCount),
    .modemRdyIn(modemRdyIn), .rxDataIn(rxDataIn), .rxClkIn(rxClkIn),
    .rdySync(rdySync), .clkEdge(clkEdge), .lastByte(lastByte),
    .outValid(outValid), .outData(outData), .outLast(outLast), .outErr(outErr)
  );
endmodule

// File: tb/rxSerialPort_test.sv
`timescale 1ns/1ps
module rxSerialPort_test;
  localparam int LEN_W = 12;
  localparam int MEAS_CYC = 64;
  localparam int GAP_CYC = 6;
  localparam int NV = 4;
  localparam int PKT_LEN [NV] = '{1, 2, 4, 3};
  localparam logic [7:0] PKT_DATA [NV][4] = '{
    '{8'hA5, 8'h00, 8'h00, 8'h00},
    '{8'h01, 8'h80, 8'h00, 8'h00},
    '{8'hFF, 8'h00, 8'h3C, 8'hC3},
    '{8'h5A, 8'h96, 8'h7E, 8'h00}
  };

  logic clk = 0, rstN = 0, startReq = 0, abortReq = 0;
  logic [LEN_W-1:0] byteCount = '0;
  logic modemRdy = 0, rxData = 0, rxClk = 0;
  logic rxEn, outValid, outLast, outErr, measValid;
  logic [7:0] outData;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  rxSerialPort #(.LEN_W(LEN_W), .MEAS_CYC(MEAS_CYC), .GAP_CYC(GAP_CYC)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .byteCount(byteCount), .rxEnOut(rxEn), .modemRdyIn(modemRdy),
    .rxDataIn(rxData), .rxClkIn(rxClk), .outValid(outValid), .outData(outData),
    .outLast(outLast), .outErr(outErr), .measValid(measValid)
  );

  always #2.5 clk = ~clk;

  // Collector, sampled on the falling edge
  logic [7:0] gotData [64];
  logic gotLast [64];
  logic gotErr [64];
  int nGot = 0, nMeas = 0, cyc = 0, riseCyc = 0, measDelta = 0;
  logic prevEn = 0;
  always @(negedge clk) begin
    cyc++;
    if (rxEn && !prevEn) riseCyc = cyc;
    prevEn = rxEn;
    if (measValid) begin nMeas++; measDelta = cyc - riseCyc; end
    if (outValid && nGot < 64) begin
      gotData[nGot] = outData; gotLast[nGot] = outLast; gotErr[nGot] = outErr;
      nGot++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    rxData = b; #40; rxClk = 1; #50; rxClk = 0; #10;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) sendBit(b[i]);
  endtask

  task automatic pulseStart();
    @(negedge clk) startReq = 1;
    @(negedge clk) startReq = 0;
  endtask

  task automatic finishRun();
    if (done) return;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #500000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    int m0;
    cycles(3);
    // R1 reset state
    chk(rxEn == 0, "R1 rxEn", rxEn, 0);
    chk(outValid == 0 && outLast == 0 && outErr == 0, "R1 out", outValid, 0);
    chk(measValid == 0, "R1 meas", measValid, 0);
    rstN = 1;
    cycles(3);

    // R2 zero count ignored
    byteCount = 0;
    pulseStart();
    cycles(3);
    chk(rxEn == 0, "R2 zero count", rxEn, 0);

    // R3 edges before ready ignored, then table of packets
    for (int v = 0; v < NV; v++) begin
      nGot = 0; m0 = nMeas;
      byteCount = LEN_W'(PKT_LEN[v]);
      pulseStart();
      chk(rxEn == 1, "R2 arm", rxEn, 1);
      if (v == 0) begin
        sendByte(8'hFF);  // modem not ready: must be dropped
        cycles(5);
        chk(nGot == 0, "R3 no ready", nGot, 0);
      end
      #100 modemRdy = 1; #1000;
      for (int b = 0; b < PKT_LEN[v]; b++) sendByte(PKT_DATA[v][b]);
      @(negedge clk);
      chk(rxEn == 0, "R4 drop after last", rxEn, 0);
      #20 modemRdy = 0;
      cycles(30);
      chk(nGot == PKT_LEN[v], "R3 beat count", nGot, PKT_LEN[v]);
      for (int b = 0; b < PKT_LEN[v] && b < nGot; b++) begin
        chk(gotData[b] == PKT_DATA[v][b], "R3 data", gotData[b], PKT_DATA[v][b]);
        chk(gotLast[b] == (b == PKT_LEN[v] - 1), "R4 last flag", gotLast[b], b == PKT_LEN[v] - 1);
        chk(gotErr[b] == 0, "R3 no err", gotErr[b], 0);
      end
      chk(nMeas - m0 == 1, "R8 one pulse", nMeas - m0, 1);
      chk(measDelta == MEAS_CYC, "R8 delay", measDelta, MEAS_CYC);
    end

    // R5 start during gap ignored, then gap length
    byteCount = 1; nGot = 0;
    pulseStart();
    #100 modemRdy = 1; #1000;
    sendByte(8'h42);
    @(negedge clk);
    chk(rxEn == 0, "R4 single byte drop", rxEn, 0);
    pulseStart();
    cycles(2);
    chk(rxEn == 0, "R5 start ignored while ready high", rxEn, 0);
    begin
      int waitCyc = 0;
      @(negedge clk) begin modemRdy = 0; startReq = 1; end
      while (!rxEn && waitCyc < 100) begin @(negedge clk); waitCyc++; end
      startReq = 0;
      chk(waitCyc >= GAP_CYC, "R5 gap length", waitCyc, GAP_CYC);
      chk(rxEn == 1, "R5 rearm", rxEn, 1);
    end

    // R6 abort before ready: immediate drop, R8 no pulse
    m0 = nMeas;
    @(negedge clk) abortReq = 1;
    @(negedge clk) abortReq = 0;
    chk(rxEn == 0, "R6 abort arm", rxEn, 0);
    cycles(MEAS_CYC + 20);
    chk(nMeas == m0, "R8 no pulse after early abort", nMeas - m0, 0);

    // R6 abort during reception
    byteCount = 4; nGot = 0;
    pulseStart();
    #100 modemRdy = 1; #1000;
    sendByte(8'h81);
    sendBit(1); sendBit(0); sendBit(1);
    @(negedge clk) abortReq = 1;
    @(negedge clk) abortReq = 0;
    cycles(4);
    chk(rxEn == 1, "R6 hold until edge", rxEn, 1);
    sendBit(1);
    @(negedge clk);
    chk(rxEn == 0, "R6 drop after edge", rxEn, 0);
    #20 modemRdy = 0;
    cycles(30);
    chk(nGot == 1, "R6 partial discarded", nGot, 1);
    chk(gotData[0] == 8'h81 && gotLast[0] == 0, "R6 first byte kept", gotData[0], 8'h81);

    // R7 truncation
    byteCount = 3; nGot = 0;
    pulseStart();
    #100 modemRdy = 1; #1000;
    sendByte(8'h17);
    sendBit(1); sendBit(1);
    modemRdy = 0;
    cycles(10);
    chk(rxEn == 0, "R7 drop", rxEn, 0);
    chk(nGot == 2, "R7 beats", nGot, 2);
    chk(gotData[0] == 8'h17, "R7 good byte", gotData[0], 8'h17);
    chk(gotErr[1] == 1 && gotLast[1] == 1 && gotData[1] == 0, "R7 err beat", gotErr[1], 1);
    cycles(30);

    finishRun();
  end
endmodule